// File: doc/BRIEF.md
# Flash Program/Erase Operation Engine

This block is the embedded operation engine that sits behind a flash command decoder. Once the decoder has recognised a complete program, chip-erase or sector-erase command, it presents one request to this engine. The engine first checks the request against the hardware and software protection rules. It then updates a behavioural byte array and holds a busy timer for a number of clocks set by a parameter. While that timer runs, every read returns a status byte in place of array data, so software can poll for completion.

The array is split into seven sectors whose sizes scale with the address width. Counted in units of 1/32 of the array, the boot sector is the top two units. Below it, going down, come two one-unit parameter sectors, a four-unit main sector and three eight-unit main sectors. A request is dropped when protection forbids it, when it arrives during the power-up hold-off, or when it arrives while an operation is still running. A dropped request never raises busy.

Top module: `flash_op_engine`

## Requirements
- R1: A program request (req_op = 01) stores old AND new data at req_addr, so programming only ever clears bits.
- R2: A sector erase (req_op = 11) sets to FFh every byte of the sector that contains req_addr, and leaves every other byte as it was. Sector units are addr[ADDR_W-1 -: 5]: 30–31 boot, 29, 28, 24–27, 16–23, 8–15 and 0–7.
- R3: A chip erase (req_op = 10) sets every byte to FFh. It leaves the boot sector untouched when tbl_n is low or boot_lock is high.
- R4: While wp_n is low, every program and erase request is dropped, whatever tbl_n and boot_lock are.
- R5: While tbl_n is low or boot_lock is high, a program or sector erase aimed at the boot sector is dropped.
- R6: A dropped request leaves busy low and the array unchanged.
- R7: An accepted program keeps busy high for exactly PROG_CLKS cycles, and an accepted erase for exactly ERASE_CLKS cycles. After that, reads return array data again with no further action.
- R8: During a program, a read at any address returns bit 7 as the inverse of bit 7 of the programmed data. During an erase, bit 7 reads 0. Bits 5:0 read 0 in both cases.
- R9: During an operation, bit 6 of the read data takes the opposite value on each successive read.
- R10: For PWRUP_CLKS cycles after reset is released, all requests are dropped.
- R11: A request that arrives while busy is high is dropped.
- R12: After reset, busy is low and every byte reads FFh. Read data appears on the clock edge that follows the cycle in which rd_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 01 program, 10 chip erase, 11 sector erase |
| req_addr | input | ADDR_W | Byte address, or any address inside the sector to erase |
| req_data | input | 8 | Data to program |
| wp_n | input | 1 | Whole-array write protect, active low |
| tbl_n | input | 1 | Boot sector lock, active low |
| boot_lock | input | 1 | Software boot lockout flag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Operation in progress |

## Verification
Every address is programmed twice with two unrelated patterns, and every byte is read back after each pass. The first pass shows the stored value, and the second shows that new data is ANDed with the old rather than written over it. A sector erase is issued once in each of the seven sectors, followed by a full read-back, so that any error in a sector boundary shows up as a wrong byte next to the sector. Chip erase and boot-sector requests are repeated under each combination of wp_n, tbl_n and boot_lock, which separates the override order of the three protection inputs. The length of busy is measured for each operation kind. Status reads are taken in both program and erase to tell the DQ7 rule for one from the rule for the other.

// File: rtl/flash_op_pkg.sv
// Shared operation codes and sector decode for the flash operation engine.
// Assumes the array is divided into 32 equal units, addressed by the top 5 address bits.
package flash_op_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_CHIP = 2'b10,
        OP_SECT = 2'b11
    } op_e;

    localparam int UNIT_W = 5;

    localparam logic [2:0] SEC_MAIN_D = 3'd0;
    localparam logic [2:0] SEC_MAIN_C = 3'd1;
    localparam logic [2:0] SEC_MAIN_B = 3'd2;
    localparam logic [2:0] SEC_MAIN_A = 3'd3;
    localparam logic [2:0] SEC_PARM_2 = 3'd4;
    localparam logic [2:0] SEC_PARM_1 = 3'd5;
    localparam logic [2:0] SEC_BOOT   = 3'd6;

    // Map a 1/32 unit index to its sector id.
    function automatic logic [2:0] sector_of(input logic [UNIT_W-1:0] unit);
        if (unit >= 5'd30)      return SEC_BOOT;
        else if (unit == 5'd29) return SEC_PARM_1;
        else if (unit == 5'd28) return SEC_PARM_2;
        else if (unit >= 5'd24) return SEC_MAIN_A;
        else if (unit >= 5'd16) return SEC_MAIN_B;
        else if (unit >= 5'd8)  return SEC_MAIN_C;
        else                    return SEC_MAIN_D;
    endfunction

endpackage

// File: rtl/flash_prot.sv
// Protection check: decides whether a request may run and whether a chip erase
// must spare the boot sector. Pure combinational; assumes sect is valid for op.
module flash_prot
    import flash_op_pkg::*;
(
    input  op_e        op,
    input  logic [2:0] sect,
    input  logic       wp_n,
    input  logic       tbl_n,
    input  logic       boot_lock,
    output logic       permit,
    output logic       spare_boot
);
    logic boot_open;

    // The boot sector is writable only with the pin high and the software lock clear.
    always_comb begin
        boot_open  = tbl_n && !boot_lock;
        spare_boot = !boot_open;
        permit     = wp_n && (op != OP_NONE) &&
                     ((op == OP_CHIP) || (sect != SEC_BOOT) || boot_open);
    end
endmodule

// File: rtl/flash_timer.sv
// Busy timer and power-up hold-off. A start loads the duration for the operation
// kind; busy stays high until the count reaches zero. Assumes ERASE_CLKS >= PROG_CLKS.
module flash_timer #(
    parameter int PROG_CLKS  = 8,
    parameter int ERASE_CLKS = 40,
    parameter int PWRUP_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_erase,
    output logic busy,
    output logic holdoff
);
    localparam int CW = $clog2(ERASE_CLKS + 1);
    localparam int PW = $clog2(PWRUP_CLKS + 1);

    logic [CW-1:0] cnt;
    logic [PW-1:0] pw_cnt;

    // Count the operation down from its duration.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= is_erase ? CW'(ERASE_CLKS) : CW'(PROG_CLKS);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Count up once after reset until the hold-off expires.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pw_cnt <= '0;
        else if (pw_cnt != PW'(PWRUP_CLKS)) pw_cnt <= pw_cnt + 1'b1;
    end

    assign busy    = (cnt != '0);
    assign holdoff = (pw_cnt != PW'(PWRUP_CLKS));

    a_r10_no_start_in_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |-> !start);
    a_r11_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(ERASE_CLKS));
endmodule

// File: rtl/flash_array.sv
// Behavioural byte array. A program ANDs data into one byte; an erase sets to FFh
// every byte of the target sector, or of the whole array except, if asked, the boot sector.
module flash_array
    import flash_op_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_prog,
    input  logic              do_erase,
    input  logic              erase_all,
    input  logic              spare_boot,
    input  logic [2:0]        tsect,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rbyte
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SHIFT = ADDR_W - UNIT_W;

    logic [7:0] mem [DEPTH];

    // Apply program or erase updates; reset leaves the array erased.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (do_prog) begin
            mem[waddr] <= mem[waddr] & wdata;
        end else if (do_erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase_all ? !(spare_boot && sector_of(UNIT_W'(i >> SHIFT)) == SEC_BOOT)
                              : (sector_of(UNIT_W'(i >> SHIFT)) == tsect))
                    mem[i] <= 8'hFF;
            end
        end
    end

    assign rbyte = mem[raddr];

    a_r1_single_update: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_prog && do_erase));
endmodule

// File: rtl/flash_status.sv
// Registered read port. While busy it returns the status byte (polling bit 7,
// toggle bit 6, zeros below); otherwise the array byte.
module flash_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       busy,
    input  logic       op_erase,
    input  logic       last_d7,
    input  logic [7:0] arr_byte,
    output logic [7:0] rd_data
);
    logic tog;

    // Capture a read, substituting status while the operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
            tog     <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= {(op_erase ? 1'b0 : ~last_d7), tog, 6'b000000};
                tog     <= ~tog;
            end else begin
                rd_data <= arr_byte;
            end
        end
    end
endmodule

// File: rtl/flash_op_engine.sv
// Top of the flash operation engine. Accepts one request at a time, applies the
// protection rules, starts the busy timer and updates the array on acceptance.
// Assumes requests come from a command decoder as single-cycle strobes.
module flash_op_engine
    import flash_op_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PROG_CLKS  = 8,
    parameter int ERASE_CLKS = 40,
    parameter int PWRUP_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              wp_n,
    input  logic              tbl_n,
    input  logic              boot_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    op_e        op;
    logic [2:0] sect;
    logic       permit, spare_boot, holdoff, start;
    logic       cur_erase, cur_d7;
    logic [7:0] arr_byte;

    assign op    = op_e'(req_op);
    assign sect  = sector_of(req_addr[ADDR_W-1 -: UNIT_W]);
    assign start = req_valid && permit && !busy && !holdoff;

    flash_prot u_prot (
        .op(op), .sect(sect), .wp_n(wp_n), .tbl_n(tbl_n), .boot_lock(boot_lock),
        .permit(permit), .spare_boot(spare_boot)
    );

    flash_timer #(.PROG_CLKS(PROG_CLKS), .ERASE_CLKS(ERASE_CLKS), .PWRUP_CLKS(PWRUP_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .is_erase(op != OP_PROG),
        .busy(busy), .holdoff(holdoff)
    );

    // Remember the kind and data bit 7 of the running operation for status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_erase <= 1'b0;
            cur_d7    <= 1'b0;
        end else if (start) begin
            cur_erase <= (op != OP_PROG);
            cur_d7    <= req_data[7];
        end
    end

    flash_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .do_prog(start && op == OP_PROG), .do_erase(start && op != OP_PROG),
        .erase_all(op == OP_CHIP), .spare_boot(spare_boot), .tsect(sect),
        .waddr(req_addr), .wdata(req_data), .raddr(rd_addr), .rbyte(arr_byte)
    );

    flash_status u_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
        .op_erase(cur_erase), .last_d7(cur_d7), .arr_byte(arr_byte), .rd_data(rd_data)
    );

    a_r4_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wp_n) |=> !$rose(busy));
    a_r5_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op != OP_CHIP && sect == SEC_BOOT) |-> (tbl_n && !boot_lock));
    a_r8_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && cur_erase) |=> (rd_data[7] == 1'b0));
    a_r6_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/sim_flash_op_engine.sv
`timescale 1ns/1ps
module sim_flash_op_engine;
    localparam int AW = 8, N = 256, PC = 8, EC = 40, PU = 16;

    logic clk = 0, rst_n = 0, req_valid = 0, wp_n = 1, tbl_n = 1, boot_lock = 0, rd_en = 0;
    logic [1:0] req_op = 0;
    logic [AW-1:0] req_addr = 0, rd_addr = 0;
    logic [7:0] req_data = 0, rd_data;
    logic busy;
    int checks = 0, errors = 0;
    logic [7:0] model [N];

    always #2.5 clk = ~clk;

    flash_op_engine #(.ADDR_W(AW), .PROG_CLKS(PC), .ERASE_CLKS(EC), .PWRUP_CLKS(PU)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .wp_n(wp_n), .tbl_n(tbl_n), .boot_lock(boot_lock),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    function automatic int region(input int a);
        if (a >= 240) return 6; else if (a >= 232) return 5; else if (a >= 224) return 4;
        else if (a >= 192) return 3; else if (a >= 128) return 2; else if (a >= 64) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
    endtask

    // Issue a request; returns with the accept edge passed, sampled at a negedge.
    task automatic issue(input logic [1:0] op, input int a, input int d);
        @(negedge clk); req_valid = 1; req_op = op; req_addr = AW'(a); req_data = 8'(d);
        @(negedge clk); req_valid = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk); rd_en = 1; rd_addr = AW'(a);
        @(negedge clk); rd_en = 0; v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v; int bad = 0;
        for (int a = 0; a < N; a++) begin
            rd(a, v);
            if (v !== model[a]) begin
                bad++;
                if (bad < 4) $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, a, v, model[a]);
            end
        end
        checks++; if (bad != 0) errors++;
    endtask

    task automatic apply_erase(input bit all, input int a, input bit spare);
        for (int i = 0; i < N; i++)
            if (all ? !(spare && region(i) == 6) : region(i) == region(a)) model[i] = 8'hFF;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2; int n;
        for (int i = 0; i < N; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R12 reset busy", busy, 0);
        rst_n = 1;
        // R10: request inside the hold-off window is dropped
        issue(2'b01, 5, 8'h00);
        chk(busy == 0, "R10 holdoff busy", busy, 0);
        rd(5, v); chk(v == 8'hFF, "R10/R12 holdoff data", v, 8'hFF);
        repeat (PU + 2) @(negedge clk);

        // R7: program duration, R8/R9 status during program
        issue(2'b01, 10, 8'h3C); model[10] = 8'h3C;
        n = 0; while (busy) begin n++; @(negedge clk); end
        chk(n == PC, "R7 program busy length", n, PC);
        issue(2'b01, 20, 8'h4B); model[20] = 8'h4B;
        rd(200, v); rd(20, v2);
        chk(v[7] == 1'b1 && v[5:0] == 0, "R8 program polling", v, 8'h80);
        chk(v2[6] != v[6], "R9 toggle", v2[6], ~v[6]);
        // R11: second request while busy is ignored
        issue(2'b01, 30, 8'h00);
        wait_idle();
        rd(20, v); chk(v == 8'h4B, "R7 auto return", v, 8'h4B);
        rd(30, v); chk(v == 8'hFF, "R11 busy request dropped", v, 8'hFF);

        // R1: two program passes over every address
        for (int a = 0; a < N; a++) begin issue(2'b01, a, (a * 37 + 11) & 255); model[a] &= 8'((a * 37 + 11) & 255); wait_idle(); end
        check_all("R1 first pass");
        for (int a = 0; a < N; a++) begin issue(2'b01, a, a ^ 8'h5A); model[a] &= 8'(a ^ 8'h5A); wait_idle(); end
        check_all("R1 AND pass");

        // R2: erase each sector in turn; R7/R8 during erase
        begin
            int tgt [7] = '{3, 70, 130, 200, 226, 233, 250};
            for (int s = 0; s < 7; s++) begin
                issue(2'b11, tgt[s], 0); apply_erase(0, tgt[s], 0);
                if (s == 0) begin
                    rd(9, v); chk(v[7] == 0 && v[5:0] == 0, "R8 erase polling", v, 0);
                    rd(9, v2); chk(v2[6] != v[6], "R9 toggle erase", v2[6], ~v[6]);
                    n = 4; while (busy) begin n++; @(negedge clk); end
                    chk(n == EC, "R7 erase busy length", n, EC);
                end
                wait_idle();
                check_all("R2 sector erase");
                for (int a = 0; a < N; a += 5) begin issue(2'b01, a, 8'h00); model[a] = 8'h00; wait_idle(); end
            end
        end

        // R4/R6: write protect drops everything
        wp_n = 0;
        issue(2'b01, 1, 8'h00); chk(busy == 0, "R4 program busy", busy, 0);
        issue(2'b11, 240, 0); chk(busy == 0, "R4 sector busy", busy, 0);
        issue(2'b10, 0, 0); chk(busy == 0, "R6 chip busy", busy, 0);
        check_all("R4 wp data unchanged");
        wp_n = 1;

        // R5: boot pin low blocks boot writes; R3 chip erase spares boot
        tbl_n = 0;
        issue(2'b01, 241, 8'h00); chk(busy == 0, "R5 tbl boot program", busy, 0);
        issue(2'b11, 255, 0); chk(busy == 0, "R5 tbl boot erase", busy, 0);
        issue(2'b01, 241 - 20, 8'h00); chk(busy == 1, "R5 tbl non-boot accepted", busy, 1);
        model[221] = 8'h00; wait_idle();
        issue(2'b10, 0, 0); apply_erase(1, 0, 1); wait_idle();
        check_all("R3 chip erase spares boot (pin)");
        tbl_n = 1;
        for (int a = 0; a < N; a += 7) begin issue(2'b01, a, 8'h11); model[a] &= 8'h11; wait_idle(); end
        boot_lock = 1;
        issue(2'b01, 250, 8'h00); chk(busy == 0, "R5 lock boot program", busy, 0);
        issue(2'b10, 0, 0); apply_erase(1, 0, 1); wait_idle();
        check_all("R3 chip erase spares boot (lock)");
        boot_lock = 0;
        issue(2'b10, 0, 0); apply_erase(1, 0, 0); wait_idle();
        check_all("R3 chip erase full");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule